// File: doc/BRIEF.md
# Translation Miss Table-Pointer Generator

When an address lookup misses in the on-chip translation cache, this block works out the memory address where a refill handler will find the matching entry in a direct-mapped, in-memory table of translations. The pointer is ready one clock after the miss is flagged. It stays readable until the next miss, so the handler can start its fetch without doing any address arithmetic.

The in-memory table can be split across several tables. A small array of table descriptors is indexed by the low bits of the context number, so that contexts which agree in those bits share one table. Context zero, the kernel, has a dedicated descriptor of its own. Each descriptor holds a base address and a size code. A context-switch strobe copies the chosen descriptor into an active register, and all later misses use that register. A write port loads the descriptors.

Top module: `miss_ptr_gen`

## Requirements
- R1: After reset `ptrValid` is 0, `ptr` is 0, and every descriptor, including the active one, holds base 0 and size code 0.
- R2: `ptrValid` is 1 in the cycle after each cycle in which `missValid` is sampled high, and 0 in every other cycle.
- R3: The pointer equals the active base plus 16 times the table index. The table index is the low (11 + size code) bits of the virtual page number.
- R4: With `missBigPage` = 0 the virtual page number is `missVa >> 13`. With `missBigPage` = 1 it is `missVa >> 16`.
- R5: A size code s from 0 to 7 selects a table of 2048·2^s entries. Page-number bits above the index width have no effect on the pointer.
- R6: `ptr` keeps its value in every cycle in which no miss is captured.
- R7: A context switch to a nonzero context c loads the descriptor at slot (c mod 4) into the active register. Contexts that agree in their low two bits get the same table.
- R8: A context switch to context 0 loads the kernel descriptor.
- R9: A descriptor write (`cfgWrKernel` = 1 for the kernel descriptor, otherwise the slot `cfgWrSlot`) has no effect on the active register or on pointers until a later context switch selects that descriptor.
- R10: A miss in the same cycle as a context switch is computed with the previous active descriptor. The next miss uses the new one.
- R11: When a write and a context switch hit the same descriptor in the same cycle, the switch loads the descriptor's old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Descriptor write enable |
| cfgWrKernel | input | 1 | Write targets the kernel descriptor |
| cfgWrSlot | input | 2 | Shared-table slot to write |
| cfgWrBase | input | 41 | Table base address to write |
| cfgWrSize | input | 3 | Size code to write (2048·2^code entries) |
| ctxSwitch | input | 1 | Context-switch strobe |
| ctxNew | input | 13 | Incoming context number |
| missValid | input | 1 | Translation miss strobe |
| missVa | input | 44 | Virtual address that missed |
| missBigPage | input | 1 | 0: 8 KB page number, 1: 64 KB page number |
| ptrValid | output | 1 | One-cycle pulse: new pointer available |
| ptr | output | 41 | Table-entry address, held between misses |

## Verification
A miss strobe sampled at a rising edge produces `ptrValid` and the new `ptr` after that same edge, with a latency of one cycle. A context switch or descriptor write also takes effect at that edge, but it changes only the register state that later misses read. The bench applies every stimulus at a falling edge and checks the outputs at the next falling edge. In that check it compares the pointer computed from the model's descriptor state before that edge's updates, which is what catches errors in the same-cycle ordering cases. Cycles without a miss are also checked, to confirm that `ptrValid` is low and `ptr` is unchanged.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam int VA_W        = 44;
  localparam int PA_W        = 41;
  localparam int CTX_W       = 13;
  localparam int SLOT_W      = 2;
  localparam int NUM_SLOTS   = 1 << SLOT_W;
  localparam int SIZE_W      = 3;
  localparam int MIN_IDX_W   = 11;
  localparam int IDX_MAX     = MIN_IDX_W + (1 << SIZE_W) - 1;
  localparam int ENTRY_SHIFT = 4;
  localparam int SMALL_SHIFT = 13;
  localparam int BIG_SHIFT   = 16;

  typedef struct packed {
    logic [PA_W-1:0]   base;
    logic [SIZE_W-1:0] size;
  } tblDesc_t;

  typedef struct packed {
    logic              capture;
    logic              loadActive;
    logic              useKernel;
    logic [SLOT_W-1:0] loadSlot;
    logic              writeSlot;
    logic              writeKernel;
    logic [SLOT_W-1:0] writeIdx;
  } dpStrobes_t;
endpackage

// File: rtl/mpg_ctrl.sv
module mpg_ctrl
  import mpg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic              ctxSwitch,
  input  logic [CTX_W-1:0]  ctxNew,
  input  logic              cfgWrEn,
  input  logic              cfgWrKernel,
  input  logic [SLOT_W-1:0] cfgWrSlot,
  output dpStrobes_t        strb,
  output logic              ptrValid
);
  always_comb begin
    strb.capture     = missValid;
    strb.loadActive  = ctxSwitch;
    strb.useKernel   = (ctxNew == '0);
    strb.loadSlot    = ctxNew[SLOT_W-1:0];
    strb.writeSlot   = cfgWrEn & ~cfgWrKernel;
    strb.writeKernel = cfgWrEn & cfgWrKernel;
    strb.writeIdx    = cfgWrSlot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptrValid <= 1'b0;
    else       ptrValid <= missValid;
  end

  AST_VALID_AFTER_MISS: assert property (@(posedge clk) disable iff (!rstN)
    missValid |=> ptrValid); // R2
  AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    !missValid |=> !ptrValid); // R2
endmodule

// File: rtl/mpg_base_table.sv
module mpg_base_table
  import mpg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              writeSlot,
  input  logic              writeKernel,
  input  logic [SLOT_W-1:0] writeIdx,
  input  logic              loadActive,
  input  logic              useKernel,
  input  logic [SLOT_W-1:0] loadSlot,
  input  tblDesc_t          wrDesc,
  output tblDesc_t          activeDesc
);
  tblDesc_t slotQ [NUM_SLOTS];
  tblDesc_t kernelQ;
  tblDesc_t activeQ;
  tblDesc_t pickDesc;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)                                      slotQ[g] <= '0;
      else if (writeSlot && (writeIdx == SLOT_W'(g))) slotQ[g] <= wrDesc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            kernelQ <= '0;
    else if (writeKernel) kernelQ <= wrDesc;
  end

  always_comb pickDesc = useKernel ? kernelQ : slotQ[loadSlot];

  always_ff @(posedge clk) begin
    if (!rstN)           activeQ <= '0;
    else if (loadActive) activeQ <= pickDesc;
  end

  assign activeDesc = activeQ;

  AST_ACTIVE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !loadActive |=> $stable(activeQ)); // R9
  AST_KERNEL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (loadActive && useKernel) |=> (activeQ == $past(kernelQ))); // R8
endmodule

// File: rtl/mpg_ptr_calc.sv
module mpg_ptr_calc
  import mpg_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            capture,
  input  tblDesc_t        activeDesc,
  input  logic [VA_W-1:0] missVa,
  input  logic            missBigPage,
  output logic [PA_W-1:0] ptr
);
  localparam int PAD_W = PA_W - IDX_MAX - ENTRY_SHIFT;

  logic [IDX_MAX-1:0] rawIdx;
  logic [IDX_MAX-1:0] idxMask;
  logic [IDX_MAX-1:0] idx;
  logic [PA_W-1:0]    offs;
  logic [PA_W-1:0]    ptrQ;
  logic               unusedVaBits;

  assign unusedVaBits = ^missVa;

  always_comb begin
    if (missBigPage) rawIdx = missVa[BIG_SHIFT +: IDX_MAX];
    else             rawIdx = missVa[SMALL_SHIFT +: IDX_MAX];
  end

  for (genvar b = 0; b < IDX_MAX; b++) begin : gMask
    if (b < MIN_IDX_W) begin : gAlways
      assign idxMask[b] = 1'b1;
    end else begin : gSized
      assign idxMask[b] = (int'(activeDesc.size) > (b - MIN_IDX_W));
    end
  end

  always_comb begin
    idx  = rawIdx & idxMask;
    offs = {{PAD_W{1'b0}}, idx, {ENTRY_SHIFT{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN)        ptrQ <= '0;
    else if (capture) ptrQ <= activeDesc.base + offs;
  end

  assign ptr = ptrQ;

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !capture |=> $stable(ptrQ)); // R6
  AST_PTR_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> (ptrQ[ENTRY_SHIFT-1:0] == $past(activeDesc.base[ENTRY_SHIFT-1:0]))); // R3
endmodule

// File: rtl/mpg_datapath.sv
module mpg_datapath
  import mpg_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobes_t      strb,
  input  tblDesc_t        wrDesc,
  input  logic [VA_W-1:0] missVa,
  input  logic            missBigPage,
  output logic [PA_W-1:0] ptr
);
  tblDesc_t activeDesc;

  mpg_base_table u_table (
    .clk        (clk),
    .rstN       (rstN),
    .writeSlot  (strb.writeSlot),
    .writeKernel(strb.writeKernel),
    .writeIdx   (strb.writeIdx),
    .loadActive (strb.loadActive),
    .useKernel  (strb.useKernel),
    .loadSlot   (strb.loadSlot),
    .wrDesc     (wrDesc),
    .activeDesc (activeDesc)
  );

  mpg_ptr_calc u_calc (
    .clk        (clk),
    .rstN       (rstN),
    .capture    (strb.capture),
    .activeDesc (activeDesc),
    .missVa     (missVa),
    .missBigPage(missBigPage),
    .ptr        (ptr)
  );
endmodule

// File: rtl/miss_ptr_gen.sv
module miss_ptr_gen
  import mpg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgWrKernel,
  input  logic [SLOT_W-1:0] cfgWrSlot,
  input  logic [PA_W-1:0]   cfgWrBase,
  input  logic [SIZE_W-1:0] cfgWrSize,
  input  logic              ctxSwitch,
  input  logic [CTX_W-1:0]  ctxNew,
  input  logic              missValid,
  input  logic [VA_W-1:0]   missVa,
  input  logic              missBigPage,
  output logic              ptrValid,
  output logic [PA_W-1:0]   ptr
);
  dpStrobes_t strb;
  tblDesc_t   wrDesc;

  assign wrDesc.base = cfgWrBase;
  assign wrDesc.size = cfgWrSize;

  mpg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .missValid  (missValid),
    .ctxSwitch  (ctxSwitch),
    .ctxNew     (ctxNew),
    .cfgWrEn    (cfgWrEn),
    .cfgWrKernel(cfgWrKernel),
    .cfgWrSlot  (cfgWrSlot),
    .strb       (strb),
    .ptrValid   (ptrValid)
  );

  mpg_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrDesc     (wrDesc),
    .missVa     (missVa),
    .missBigPage(missBigPage),
    .ptr        (ptr)
  );
endmodule

// File: tb/miss_ptr_gen_bench.sv
`timescale 1ns/1ps
module miss_ptr_gen_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn, cfgWrKernel;
  logic [1:0]  cfgWrSlot;
  logic [40:0] cfgWrBase;
  logic [2:0]  cfgWrSize;
  logic        ctxSwitch;
  logic [12:0] ctxNew;
  logic        missValid;
  logic [43:0] missVa;
  logic        missBigPage;
  logic        ptrValid;
  logic [40:0] ptr;

  int compared = 0;
  int mismatched = 0;

  logic [40:0] mSlotBase [4];
  logic [2:0]  mSlotSize [4];
  logic [40:0] mKBase, aBase, lastPtr;
  logic [2:0]  mKSize, aSize;

  always #4 clk = ~clk;

  miss_ptr_gen u_miss_ptr_gen (.*);

  function automatic logic [40:0] expPtr(logic [40:0] b, logic [2:0] s, logic [43:0] va, logic big);
    logic [43:0] vpn;
    logic [43:0] idx;
    vpn = big ? (va >> 16) : (va >> 13);
    idx = vpn & ((44'd1 << (11 + s)) - 44'd1);
    return b + 41'(idx << 4);
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit doWr, bit wrK, logic [1:0] wrSlot, logic [40:0] wrBase, logic [2:0] wrSize,
                      bit doSw, logic [12:0] ctx, bit doMiss, logic [43:0] va, bit big, string tag);
    logic [40:0] e;
    cfgWrEn = doWr; cfgWrKernel = wrK; cfgWrSlot = wrSlot; cfgWrBase = wrBase; cfgWrSize = wrSize;
    ctxSwitch = doSw; ctxNew = ctx; missValid = doMiss; missVa = va; missBigPage = big;
    e = expPtr(aBase, aSize, va, big);            // R10: miss sees previous active
    if (doSw) begin                               // R11: switch reads before write
      if (ctx == 13'd0) begin aBase = mKBase; aSize = mKSize; end
      else begin aBase = mSlotBase[ctx[1:0]]; aSize = mSlotSize[ctx[1:0]]; end
    end
    if (doWr) begin
      if (wrK) begin mKBase = wrBase; mKSize = wrSize; end
      else begin mSlotBase[wrSlot] = wrBase; mSlotSize[wrSlot] = wrSize; end
    end
    @(negedge clk);
    cfgWrEn = 0; ctxSwitch = 0; missValid = 0;
    if (doMiss) begin
      check(ptrValid === 1'b1, {tag, " R2 valid"}, 64'(ptrValid), 64'd1);
      check(ptr === e, tag, 64'(ptr), 64'(e));
      lastPtr = e;
    end else begin
      check(ptrValid === 1'b0, {tag, " R2 idle"}, 64'(ptrValid), 64'd0);
      check(ptr === lastPtr, {tag, " R6 hold"}, 64'(ptr), 64'(lastPtr));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [43:0] va;
    void'($urandom(32'd2024));
    rstN = 0; cfgWrEn = 0; cfgWrKernel = 0; cfgWrSlot = 0; cfgWrBase = 0; cfgWrSize = 0;
    ctxSwitch = 0; ctxNew = 0; missValid = 0; missVa = 0; missBigPage = 0;
    for (int i = 0; i < 4; i++) begin mSlotBase[i] = 0; mSlotSize[i] = 0; end
    mKBase = 0; mKSize = 0; aBase = 0; aSize = 0; lastPtr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(ptrValid === 1'b0, "R1 reset valid", 64'(ptrValid), 64'd0);
    check(ptr === 41'd0, "R1 reset ptr", 64'(ptr), 64'd0);

    va = 44'hABC_DEF1_2345;
    step(0,0,0,0,0, 0,0, 1, va, 0, "R1 zero base miss");
    step(0,0,0,0,0, 0,0, 0, 0, 0, "R6 idle");
    step(1,0,2'd1,41'h1_0000_0000,3'd2, 0,0, 1, va, 0, "R9 write not active");
    step(0,0,0,0,0, 1,13'd5, 0, 0, 0, "R7 switch");
    step(0,0,0,0,0, 0,0, 1, va, 0, "R7 slot1 via ctx5");
    step(0,0,0,0,0, 0,0, 1, va, 1, "R4 big page");
    step(0,0,0,0,0, 1,13'd9, 1, 44'h123_4567_89AB, 0, "R7 ctx9 shares");
    step(1,1,0,41'h0_8000_0000,3'd7, 0,0, 0, 0, 0, "R9 kernel write");
    step(0,0,0,0,0, 1,13'd0, 1, va, 0, "R10 switch with miss old base");
    step(0,0,0,0,0, 0,0, 1, va, 0, "R8 kernel base");
    step(0,0,0,0,0, 0,0, 1, 44'hFFF_FFFF_FFFF, 0, "R5 size7 all ones");
    step(0,0,0,0,0, 0,0, 1, 44'hFFF_FFFF_FFFF, 1, "R5 size7 big");
    step(1,0,2'd3,41'h2_0000_0000,3'd0, 1,13'd3, 0, 0, 0, "R11 write+switch same slot");
    step(0,0,0,0,0, 0,0, 1, 44'hFFF_FFFF_FFFF, 0, "R11 old slot3 contents");
    step(0,0,0,0,0, 1,13'd7, 1, va, 0, "R10 switch");
    step(0,0,0,0,0, 0,0, 1, 44'hFFF_FFFF_FFFF, 0, "R5 size0 truncation");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], r[3:2], {$urandom, $urandom} & 41'h1FF_FFFF_FFF0, r[6:4],
           r[7] & r[8], (r[9] ? 13'd0 : 13'($urandom)), r[10] | r[11],
           44'({$urandom, $urandom}), r[12], "R3 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule